// File: doc/BRIEF.md
# Two-Source Interrupt Register Block with Event and Status Sources

This block holds the interrupt registers of a small transfer engine that has two interrupt sources: transfer done (source 0) and bus error (source 1). Each source is either Event-type or Status-type, chosen per source by a parameter bit mask. An Event-type source latches into a state bit that software clears by writing 1 to it. A Status-type source has no latch of its own: its state bit is the OR of a hardware status flag and a held test request. Software clears the hardware flag through the status register.

Hardware raises the flags with single-cycle pulses. Software drives one register write per cycle through a select/data pair and reads any register combinationally. Each source drives one registered interrupt line, which equals its state bit ANDed with its enable bit.

Top module: `dma_irq_regs`

## Requirements
- R1: While reset is low, and right after it, every interrupt line is 0, and the enable, state, test and status registers read as 0.
- R2: Register select 0 is the enable register, with bit 0 for done and bit 1 for error. Each interrupt line equals state AND enable. The line updates on the same clock edge that the write or pulse responsible for the change is taken.
- R3: Select 3 is the status register. A pulse on the done input sets status bit 0, and a pulse on the error input sets status bit 1. Both bits stay set until cleared.
- R4: Select 1 is the state register. For a Status-type source, the state bit reads as the held test bit OR the status flag.
- R5: For a Status-type source, a write to the state register has no effect.
- R6: Writing 1 to a status-register bit clears that flag. A Status-type interrupt then drops unless its held test bit is still 1.
- R7: Select 2 is the test register. For an Event-type source, a test write of 1 sets the state bit. The bit stays set when the test bit is later written to 0, and it clears only when 1 is written to its state-register bit.
- R8: For an Event-type source, a hardware pulse sets the state bit. Clearing the matching status flag leaves the Event state bit set.
- R9: When a hardware pulse and a software clear hit the same bit in the same cycle, the bit ends up set. This applies to both status flags and Event state bits.
- R10: Write data bits above bit 1 are ignored, and read data bits above bit 1 are 0.
- R11: The test register reads back the held test bits of the Status-type sources. Bits of Event-type sources read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_pulse_i | input | 1 | Pulse when the final destination write completes |
| err_pulse_i | input | 1 | Pulse on a bus error during a transfer |
| wr_valid_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 enable, 1 state, 2 test, 3 status |
| wr_data_i | input | DW | Write data |
| rd_sel_i | input | 2 | Read target, same encoding as wr_sel_i |
| rd_data_o | output | DW | Combinational read data |
| irq_o | output | 2 | Interrupt lines, bit 0 done, bit 1 error |

## Verification
The hardest situation to reach is a collision on one bit: a hardware pulse arriving in the same cycle as a software clear of that bit. The Status-type case where a held test bit keeps an interrupt up after its flag is cleared is similarly hard. Random stimulus seldom lines up these events with the right enable and test state. Directed sequences therefore build each situation step by step before the random phase runs. The stimulus drives two instances in parallel, one with both sources Status-type and one with the error source Event-type, so the same inputs exercise both kinds of source.

// File: rtl/dma_irq_regs.sv
module dma_irq_regs #(
  parameter int         DW          = 32,
  parameter logic [1:0] STATUS_MASK = 2'b11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_pulse_i,
  input  logic          err_pulse_i,
  input  logic          wr_valid_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    rd_sel_i,
  output logic [DW-1:0] rd_data_o,
  output logic [1:0]    irq_o
);
  localparam int NSRC = 2;
  localparam logic [1:0] SEL_EN = 2'd0, SEL_ST = 2'd1, SEL_TST = 2'd2, SEL_STS = 2'd3;

  logic [NSRC-1:0] en_q, evt_q, tst_q, hw_q, irq_q;
  logic [NSRC-1:0] en_d, evt_d, tst_d, hw_d;
  logic [NSRC-1:0] wd, hw_set, state_w, state_d;
  logic            w_en, w_st, w_tst, w_sts;

  assign wd     = wr_data_i[NSRC-1:0];
  assign hw_set = {err_pulse_i, done_pulse_i};
  assign w_en   = wr_valid_i && wr_sel_i == SEL_EN;
  assign w_st   = wr_valid_i && wr_sel_i == SEL_ST;
  assign w_tst  = wr_valid_i && wr_sel_i == SEL_TST;
  assign w_sts  = wr_valid_i && wr_sel_i == SEL_STS;

  always_comb begin
    en_d  = w_en  ? wd : en_q;
    tst_d = w_tst ? (wd & STATUS_MASK) : tst_q;
    hw_d  = (hw_q & ~(w_sts ? wd : '0)) | hw_set;
    evt_d = ((evt_q & ~(w_st ? wd : '0)) | hw_set | (w_tst ? wd : '0)) & ~STATUS_MASK;
  end

  assign state_w = (STATUS_MASK & (tst_q | hw_q)) | (~STATUS_MASK & evt_q);
  assign state_d = (STATUS_MASK & (tst_d | hw_d)) | (~STATUS_MASK & evt_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      evt_q <= '0;
      tst_q <= '0;
      hw_q  <= '0;
      irq_q <= '0;
    end else begin
      en_q  <= en_d;
      evt_q <= evt_d;
      tst_q <= tst_d;
      hw_q  <= hw_d;
      irq_q <= state_d & en_d;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    rd_data_o = '0;
    case (rd_sel_i)
      SEL_EN:  rd_data_o[NSRC-1:0] = en_q;
      SEL_ST:  rd_data_o[NSRC-1:0] = state_w;
      SEL_TST: rd_data_o[NSRC-1:0] = tst_q;
      default: rd_data_o[NSRC-1:0] = hw_q;
    endcase
  end
endmodule

// File: rtl/dma_irq_regs_chk.sv
module dma_irq_regs_chk #(
  parameter int         DW          = 32,
  parameter logic [1:0] STATUS_MASK = 2'b11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_pulse_i,
  input logic          err_pulse_i,
  input logic          wr_valid_i,
  input logic [1:0]    wr_sel_i,
  input logic [DW-1:0] wr_data_i,
  input logic [1:0]    irq_o,
  input logic [1:0]    hw_q,
  input logic [1:0]    state_w
);
  a_r2_enable_gates_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_sel_i == 2'd0) |=> ((irq_o & ~$past(wr_data_i[1:0])) == 2'b00));

  a_r3_done_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse_i |=> hw_q[0]);

  a_r3_err_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_i |=> hw_q[1]);

  a_r5_state_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_sel_i == 2'd1 && !done_pulse_i && !err_pulse_i)
    |=> $stable(state_w & STATUS_MASK));

  a_r6_status_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_sel_i == 2'd3 && wr_data_i[0] && !done_pulse_i) |=> !hw_q[0]);

  a_r9_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_pulse_i && wr_valid_i && wr_sel_i == 2'd3 && wr_data_i[1]) |=> hw_q[1]);
endmodule

bind dma_irq_regs dma_irq_regs_chk #(.DW(DW), .STATUS_MASK(STATUS_MASK)) chk_i (.*);

// File: tb/dma_irq_regs_tb_top.sv
module dma_irq_regs_tb_top;
  localparam int DW = 32;
  localparam logic [1:0] MASK_A = 2'b11, MASK_B = 2'b01;
  localparam logic [1:0] S_EN = 2'd0, S_ST = 2'd1, S_TST = 2'd2, S_STS = 2'd3;

  typedef struct packed { logic [1:0] en, evt, tst, hw; } mstate_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic done_p = 1'b0, err_p = 1'b0, wv = 1'b0;
  logic [1:0] wsel = '0, rsel = '0;
  logic [DW-1:0] wdata = '0, rd_a, rd_b;
  logic [1:0] irq_a, irq_b;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  mstate_t ma, mb;

  always #4 clk = ~clk;

  dma_irq_regs #(.DW(DW), .STATUS_MASK(MASK_A)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .done_pulse_i(done_p), .err_pulse_i(err_p),
    .wr_valid_i(wv), .wr_sel_i(wsel), .wr_data_i(wdata), .rd_sel_i(rsel),
    .rd_data_o(rd_a), .irq_o(irq_a));

  dma_irq_regs #(.DW(DW), .STATUS_MASK(MASK_B)) dut_mix_i (
    .clk_i(clk), .rst_ni(rst_ni), .done_pulse_i(done_p), .err_pulse_i(err_p),
    .wr_valid_i(wv), .wr_sel_i(wsel), .wr_data_i(wdata), .rd_sel_i(rsel),
    .rd_data_o(rd_b), .irq_o(irq_b));

  function automatic mstate_t mnext(mstate_t s, logic [1:0] m, logic d, logic e,
                                    logic v, logic [1:0] sel, logic [DW-1:0] data);
    mstate_t n;
    logic [1:0] b;
    b = data[1:0];
    n = s;
    if (v && sel == S_EN) n.en = b;
    if (v && sel == S_TST) n.tst = b & m;
    if (v && sel == S_STS) n.hw = n.hw & ~b;
    n.hw = n.hw | {e, d};
    if (v && sel == S_ST) n.evt = n.evt & ~b;
    n.evt = (n.evt | {e, d} | ((v && sel == S_TST) ? b : 2'b00)) & ~m;
    return n;
  endfunction

  function automatic logic [1:0] mstate(mstate_t s, logic [1:0] m);
    return (m & (s.tst | s.hw)) | (~m & s.evt);
  endfunction

  function automatic logic [DW-1:0] mread(mstate_t s, logic [1:0] m, logic [1:0] sel);
    logic [1:0] v;
    case (sel)
      S_EN:    v = s.en;
      S_ST:    v = mstate(s, m);
      S_TST:   v = s.tst;
      default: v = s.hw;
    endcase
    return {{(DW-2){1'b0}}, v};
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic d, logic e, logic v, logic [1:0] sel, logic [DW-1:0] data,
                      logic [1:0] rs, string tag);
    done_p = d; err_p = e; wv = v; wsel = sel; wdata = data; rsel = rs;
    @(posedge clk);
    ma = mnext(ma, MASK_A, d, e, v, sel, data);
    mb = mnext(mb, MASK_B, d, e, v, sel, data);
    @(negedge clk);
    done_p = 0; err_p = 0; wv = 0;
    check({tag, " irq A"}, {30'd0, irq_a}, {30'd0, mstate(ma, MASK_A) & ma.en});
    check({tag, " irq B"}, {30'd0, irq_b}, {30'd0, mstate(mb, MASK_B) & mb.en});
    check({tag, " read A"}, rd_a, mread(ma, MASK_A, rs));
    check({tag, " read B"}, rd_b, mread(mb, MASK_B, rs));
  endtask

  task automatic do_reset();
    rst_ni = 0; ma = '0; mb = '0;
    repeat (3) @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      rsel = 2'(s); #1;
      check("R1 read A in reset", rd_a, '0);
      check("R1 read B in reset", rd_b, '0);
    end
    check("R1 irq in reset", {30'd0, irq_a | irq_b}, '0);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    step(0, 0, 1, S_EN, 32'h3, S_EN, "R2");
    check("R2 no line before flags", {30'd0, irq_a}, 32'h0);
    step(1, 0, 0, S_EN, 0, S_ST, "R3");
    check("R3 done line", {30'd0, irq_a}, 32'h1);
    step(0, 0, 1, S_TST, 32'h1, S_TST, "R4");
    step(0, 0, 1, S_STS, 32'h1, S_STS, "R6");
    check("R6 test holds line", {30'd0, irq_a}, 32'h1);
    check("R6 flag cleared", rd_a, 32'h0);
    step(0, 0, 1, S_TST, 32'h0, S_ST, "R6");
    check("R6 line drops", {30'd0, irq_a}, 32'h0);
    step(0, 1, 0, S_EN, 0, S_ST, "R3");
    step(0, 0, 1, S_ST, 32'h3, S_ST, "R5");
    check("R5 status state kept", rd_a, 32'h2);
    check("R7 event state cleared", rd_b, 32'h0);
    step(0, 0, 1, S_STS, 32'h2, S_STS, "R8");
    step(0, 0, 1, S_TST, 32'h2, S_TST, "R11");
    check("R11 event test reads zero", rd_b, 32'h0);
    check("R7 event test raises line", {30'd0, irq_b}, 32'h2);
    step(0, 0, 1, S_TST, 32'h0, S_ST, "R7");
    check("R7 event state stays", rd_b, 32'h2);
    step(0, 0, 1, S_ST, 32'h2, S_ST, "R7");
    step(0, 1, 0, S_EN, 0, S_ST, "R8");
    step(0, 0, 1, S_STS, 32'h2, S_ST, "R8");
    check("R8 event survives status clear", rd_b, 32'h2);
    step(1, 0, 1, S_STS, 32'h1, S_STS, "R9");
    check("R9 flag set wins", rd_a, 32'h1);
    step(0, 1, 1, S_ST, 32'h2, S_ST, "R9");
    check("R9 event set wins", rd_b & 32'h2, 32'h2);
    step(0, 0, 1, S_EN, 32'hFFFF_FFFC, S_EN, "R10");
    check("R10 upper bits ignored", rd_a, 32'h0);
    check("R10 lines off", {30'd0, irq_a}, 32'h0);

    for (int i = 0; i < 600; i++) begin
      logic [DW-1:0] rw;
      rw = $urandom();
      if ($urandom_range(3) == 0) rw = rw | 32'h3;
      step($urandom_range(5) == 0, $urandom_range(5) == 0, $urandom_range(1) == 1,
           2'($urandom_range(3)), rw, 2'($urandom_range(3)), "R2 R4 random");
    end

    do_reset();
    step(0, 0, 0, S_EN, 0, S_ST, "R1");
    check("R1 state after reset", rd_a, 32'h0);
    finished = 1;
    report();
  end
endmodule